// File: doc/BRIEF.md
# Single-Shot Successive-Approximation Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter. Software writes a mode byte whose top bit launches one conversion. The controller then holds a sampling phase for a programmed number of clocks. After that it tests one bit per clock, most significant bit first, by placing a trial code on the DAC output and reading back a single comparator bit. When the last bit has been decided, the code goes into two byte-wide result registers, the start bit drops back to 0, and a one-clock completion pulse is raised.

Two cases need a fixed rule because they can happen in the same clock as the final result store. If software reads a result register in that clock, the read gets the old value and the store waits one clock. If software writes the mode register in that clock, the mode write wins: the stored results do not change and no completion pulse is produced. Writing 0 to the start bit during a conversion abandons it.

The analog sample-and-hold, the DAC and the comparator are outside the block. A resolution bit in the mode byte selects an 8-bit or a 10-bit conversion.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, the mode byte (address 0), the upper result byte (address 1) and the lower result byte (address 2) all read 00h, and `conv_done_irq` is low. `bus_rdata` shows the addressed byte in the same cycle that `bus_rd` is high.
- R2: A write to address 0 with bit 7 set, made while idle, starts exactly one conversion. Its sampling phase lasts (mode bits 3..0)+1 clocks, and `dac_code` is 0 during sampling and whenever the block is idle.
- R3: Approximation takes one clock per bit, most significant bit first. The first trial code is 200h. A trial bit is kept when `cmp_above` is 1, meaning the input is at or above the DAC level, so the final code equals the input code, including the all-ones input.
- R4: Bit 7 of the mode byte reads 1 while a conversion runs and reads 0 once it ends. `conv_done_irq` is high for exactly one clock, in the clock after the last bit decision, and the new results are readable in that same clock.
- R5: In 10-bit mode (mode bit 6 = 0), the upper result byte holds code bits 9..2. The lower result byte holds code bits 1..0 in its bits 7..6, and its bits 5..0 are 0.
- R6: In 8-bit mode (mode bit 6 = 1), eight decisions are made. Only the upper result byte is written, with code bits 9..2, and the lower byte keeps its previous value.
- R7: A read of address 1 or 2 in the clock of the last decision returns the old value. The results are stored one clock later, and `conv_done_irq` also comes one clock later.
- R8: A write to address 0 in the clock of the last decision takes effect as written. The result bytes are left unchanged and no `conv_done_irq` pulse follows.
- R9: Writing address 0 with bit 7 clear during sampling or approximation returns the block to idle. No pulse follows, and the result bytes keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 2 | Byte register address: 0 mode, 1 upper result, 2 lower result |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while `bus_rd` is high, 0 otherwise |
| dac_code | output | DATA_W | Trial code sent to the external DAC |
| cmp_above | input | 1 | Comparator output: 1 when the input is at or above the DAC level |
| conv_done_irq | output | 1 | One-clock completion pulse |

## Verification
Each check is timed from the clock edge that accepts the start write. Sampling then occupies (field+1) clocks, and approximation occupies 10 or 8 clocks. The completion pulse and the new results are due in the next clock, or one clock after that when a read collides with the store. The bench steps to exactly those cycles on falling edges. It checks that the pulse is absent in every earlier cycle and present in the due cycle, and it reads the result bytes there. For the collision and abort cases, it places its bus access in the exact clock of the last decision or in a chosen sampling or approximation clock. It then reads the bytes back before any later stimulus is applied.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_CONV   = 2'd2
  } sar_phase_e;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_LO   = 2'd2;
  localparam int START_BIT = 7;
  localparam int RES8_BIT  = 6;
endpackage

// File: rtl/sar_timing.sv
module sar_timing
  import sar_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int SMP_W  = 4,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             abort,
  input  logic             res8_in,
  input  logic [SMP_W-1:0] smp_len,
  output sar_phase_e       phase_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             res8_o,
  output logic             eoc_o
);
  localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] IDX_STOP8 = IDX_W'(DATA_W - 8);

  sar_phase_e       phase_q, phase_d;
  logic [SMP_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             res8_q, res8_d;
  logic             last_bit;

  assign last_bit = (idx_q == (res8_q ? IDX_STOP8 : '0));
  assign eoc_o    = (phase_q == PH_CONV) && last_bit;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    res8_d  = res8_q;
    case (phase_q)
      PH_SAMPLE: begin
        if (cnt_q == '0) begin
          phase_d = PH_CONV;
          idx_d   = IDX_TOP;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_CONV: begin
        if (last_bit) phase_d = PH_IDLE;
        else          idx_d   = idx_q - 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
    if (abort) begin
      phase_d = PH_IDLE;
    end else if (launch) begin
      phase_d = PH_SAMPLE;
      cnt_d   = smp_len;
      res8_d  = res8_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      res8_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      res8_q  <= res8_d;
    end
  end

  assign phase_o   = phase_q;
  assign bit_idx_o = idx_q;
  assign res8_o    = res8_q;

  // R3: approximation always opens on the most significant bit
  assert_msb_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CONV && $past(phase_q) == PH_SAMPLE) |-> (idx_q == IDX_TOP));
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int DATA_W = 10,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              cmp_above,
  output logic [DATA_W-1:0] dac_code,
  output logic [DATA_W-1:0] final_code
);
  logic [DATA_W-1:0] sar_q, sar_d;
  logic [DATA_W-1:0] trial;

  assign trial      = DATA_W'(1) << bit_idx;
  assign final_code = sar_q | (cmp_above ? trial : '0);
  assign dac_code   = step ? (sar_q | trial) : '0;

  always_comb begin
    sar_d = sar_q;
    if (clear)     sar_d = '0;
    else if (step) sar_d = final_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sar_q <= '0;
    else        sar_q <= sar_d;
  end
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eoc,
  input  logic [DATA_W-1:0] code_in,
  input  logic              res8,
  input  logic              mode_wr,
  input  logic              res_rd,
  output logic [7:0]        res_hi,
  output logic [7:0]        res_lo,
  output logic              irq
);
  localparam int LOW_BITS = DATA_W - 8;

  logic              pend_q, pend_d;
  logic [DATA_W-1:0] pcode_q, pcode_d;
  logic              pres8_q, pres8_d;
  logic [7:0]        hi_q, hi_d, lo_q, lo_d;
  logic              irq_q, irq_d;
  logic              commit;
  logic [DATA_W-1:0] wcode;
  logic              wres8;
  logic [7:0]        lo_packed;

  assign commit = (eoc && !mode_wr && !res_rd) || pend_q;
  assign wcode  = pend_q ? pcode_q : code_in;
  assign wres8  = pend_q ? pres8_q : res8;

  generate
    if (LOW_BITS == 8) begin : g_full_low
      assign lo_packed = wcode[7:0];
    end else begin : g_part_low
      assign lo_packed = {wcode[LOW_BITS-1:0], {(8-LOW_BITS){1'b0}}};
    end
  endgenerate

  always_comb begin
    pend_d  = eoc && !mode_wr && res_rd;
    pcode_d = pcode_q;
    pres8_d = pres8_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    irq_d   = commit;
    if (pend_d) begin
      pcode_d = code_in;
      pres8_d = res8;
    end
    if (commit) begin
      hi_d = wcode[DATA_W-1 -: 8];
      if (!wres8) lo_d = lo_packed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      pcode_q <= '0;
      pres8_q <= 1'b0;
      hi_q    <= 8'h00;
      lo_q    <= 8'h00;
      irq_q   <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      pcode_q <= pcode_d;
      pres8_q <= pres8_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      irq_q   <= irq_d;
    end
  end

  assign res_hi = hi_q;
  assign res_lo = lo_q;
  assign irq    = irq_q;

  // R4: completion is a single-clock pulse
  assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R8: a mode write at end of conversion suppresses store and pulse
  assert_mode_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && mode_wr) |=> (!irq_q && $stable(hi_q) && $stable(lo_q)));
  // R7: a colliding read pushes the store back by one clock
  assert_read_defers_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && res_rd && !mode_wr) |=> (!irq_q && $stable(hi_q)) ##1 irq_q);
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int SMP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [DATA_W-1:0] dac_code,
  input  logic              cmp_above,
  output logic              conv_done_irq
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [7:0] MODE_MASK = 8'hC0 | 8'((1 << SMP_W) - 1);

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [7:0]        mode_q, mode_d;
  logic              mode_wr, res_rd, busy, launch, abort;
  sar_phase_e        phase;
  logic [IDX_W-1:0]  bit_idx;
  logic              res8_lat, eoc;
  logic [DATA_W-1:0] final_code;
  logic [7:0]        res_hi, res_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign mode_wr = bus_wr && (bus_addr == ADDR_MODE);
  assign res_rd  = bus_rd && ((bus_addr == ADDR_HI) || (bus_addr == ADDR_LO));
  assign busy    = (phase != PH_IDLE);
  assign launch  = mode_wr && bus_wdata[START_BIT] && (!busy || eoc);
  assign abort   = mode_wr && !bus_wdata[START_BIT] && busy;

  always_comb begin
    mode_d = mode_q;
    if (mode_wr)  mode_d = bus_wdata & MODE_MASK;
    else if (eoc) mode_d[START_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) mode_q <= 8'h00;
    else             mode_q <= mode_d;
  end

  sar_timing #(.DATA_W(DATA_W), .SMP_W(SMP_W)) u_timing (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .launch    (launch),
    .abort     (abort),
    .res8_in   (bus_wdata[RES8_BIT]),
    .smp_len   (bus_wdata[SMP_W-1:0]),
    .phase_o   (phase),
    .bit_idx_o (bit_idx),
    .res8_o    (res8_lat),
    .eoc_o     (eoc)
  );

  sar_approx #(.DATA_W(DATA_W)) u_approx (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clear      (launch),
    .step       (phase == PH_CONV),
    .bit_idx    (bit_idx),
    .cmp_above  (cmp_above),
    .dac_code   (dac_code),
    .final_code (final_code)
  );

  sar_result #(.DATA_W(DATA_W)) u_result (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .eoc     (eoc),
    .code_in (final_code),
    .res8    (res8_lat),
    .mode_wr (mode_wr),
    .res_rd  (res_rd),
    .res_hi  (res_hi),
    .res_lo  (res_lo),
    .irq     (conv_done_irq)
  );

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      case (bus_addr)
        ADDR_MODE: bus_rdata = mode_q;
        ADDR_HI:   bus_rdata = res_hi;
        ADDR_LO:   bus_rdata = res_lo;
        default:   bus_rdata = 8'h00;
      endcase
    end
  end

  // R9/R2: the DAC rests at zero whenever the sequencer is idle
  assert_idle_dac_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase == PH_IDLE) |-> (dac_code == '0));
  // R4: the start bit has dropped by the time the pulse is seen
  assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(conv_done_irq) && !$past(mode_wr)) |-> !mode_q[START_BIT]);
  // R2: a conversion begins with its sampling phase
  assert_sample_first_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (launch && !abort) |=> (phase == PH_SAMPLE));
endmodule

// File: tb/tb_sar_adc_seq.sv
module tb_sar_adc_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic [9:0] dac_code;
  logic [9:0] vin;
  logic       cmp_above, conv_done_irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  assign cmp_above = (vin >= dac_code);

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_adc_seq dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dac_code(dac_code), .cmp_above(cmp_above), .conv_done_irq(conv_done_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1; #1; d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic expect_results(input logic [7:0] hi, input logic [7:0] lo, input string tag);
    logic [7:0] d;
    rd(2'd1, d); chk(d == hi, {tag, " upper"}, d, hi);
    rd(2'd2, d); chk(d == lo, {tag, " lower"}, d, lo);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0; vin = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd0, d); chk(d == 8'h00, "R1 mode", d, 0);
    expect_results(8'h00, 8'h00, "R1 reset");
    chk(conv_done_irq == 1'b0, "R1 irq", conv_done_irq, 0);
  endtask

  // full conversion with cycle-exact pulse timing
  task automatic t_conv(input logic [9:0] v, input bit res8, input int smp,
                        input logic [7:0] exp_hi, input logic [7:0] exp_lo);
    logic [7:0] d;
    int nb = res8 ? 8 : 10;
    bit dac_ok = 1;
    vin = v;
    wr(2'd0, 8'h80 | (res8 ? 8'h40 : 8'h00) | 8'(smp));
    for (int k = 0; k < smp + 1; k++) begin
      if (dac_code != 0) dac_ok = 0;
      if (conv_done_irq) chk(0, "R4 early pulse in sampling", 1, 0);
      @(negedge clk);
    end
    chk(dac_ok, "R2 dac zero during sampling", dac_ok, 1);
    chk(dac_code == 10'h200, "R3 first trial code", dac_code, 10'h200);
    rd(2'd0, d); chk(d[7] == 1'b1, "R4 start reads 1 while busy", d[7], 1);
    for (int k = 0; k < nb; k++) begin
      if (conv_done_irq) chk(0, "R4 early pulse in approximation", 1, 0);
      @(negedge clk);
    end
    chk(conv_done_irq == 1'b1, "R4 pulse due", conv_done_irq, 1);
    expect_results(exp_hi, exp_lo, res8 ? "R6 8-bit result" : "R5 10-bit result");
    rd(2'd0, d); chk(d[7] == 1'b0, "R4 start self-clears", d[7], 0);
    @(negedge clk);
    chk(conv_done_irq == 1'b0, "R4 pulse one clock", conv_done_irq, 1'b0);
    begin
      bit quiet = 1;
      for (int k = 0; k < 20; k++) begin
        if (conv_done_irq || dac_code != 0) quiet = 0;
        @(negedge clk);
      end
      chk(quiet, "R2 exactly one conversion", quiet, 1);
    end
  endtask

  task automatic t_read_collide;
    logic [7:0] d;
    vin = 10'h0AA;
    wr(2'd0, 8'h80);
    repeat (1 + 10 - 1) @(negedge clk);
    bus_addr = 2'd1; bus_rd = 1'b1; #1;
    chk(bus_rdata == 8'h55, "R7 colliding read returns old", bus_rdata, 8'h55);
    @(negedge clk); bus_rd = 1'b0;
    chk(conv_done_irq == 1'b0, "R7 pulse deferred", conv_done_irq, 0);
    expect_results(8'h55, 8'hC0, "R7 store deferred");
    @(negedge clk);
    chk(conv_done_irq == 1'b1, "R7 pulse one clock late", conv_done_irq, 1);
    expect_results(8'h2A, 8'h80, "R7 stored after read");
    repeat (3) @(negedge clk);
  endtask

  task automatic t_mode_collide;
    logic [7:0] d;
    bit quiet = 1;
    vin = 10'h3FF;
    wr(2'd0, 8'h81);
    repeat (2 + 10 - 1) @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 8'h05; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (conv_done_irq) quiet = 0;
      @(negedge clk);
    end
    chk(quiet, "R8 no pulse", quiet, 1);
    expect_results(8'h2A, 8'h80, "R8 results kept");
    rd(2'd0, d); chk(d == 8'h05, "R8 mode write applied", d, 8'h05);
  endtask

  task automatic t_abort(input int at_cycle, input string tag);
    logic [7:0] d;
    bit quiet = 1;
    vin = 10'h3FF;
    wr(2'd0, 8'h83);
    repeat (at_cycle) @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 8'h03; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (conv_done_irq || dac_code != 0) quiet = 0;
      @(negedge clk);
    end
    chk(quiet, {tag, " no pulse, dac idle"}, quiet, 1);
    expect_results(8'h2A, 8'h80, {tag, " results kept"});
    rd(2'd0, d); chk(d[7] == 1'b0, {tag, " start cleared"}, d[7], 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_conv(10'h2B5, 0, 2, 8'hAD, 8'h40);   // R5 packing, R3
    t_conv(10'h3FF, 0, 0, 8'hFF, 8'hC0);   // R3 equality kept on every bit
    t_conv(10'h155, 1, 4, 8'h55, 8'hC0);   // R6 lower byte untouched
    t_read_collide();                      // R7
    t_mode_collide();                      // R8
    t_abort(1, "R9 abort in sampling");
    t_abort(6, "R9 abort in approximation");
    t_conv(10'h000, 0, 15, 8'h00, 8'h00);  // R2 longest sampling, R5 zero code
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule